// File: doc/BRIEF.md
# Trace timestamp source selector

This block forms the timestamp value written into trace records. It takes a free-running physical counter and presents one of three views of it: the raw count, the count minus a virtual offset, or the count minus a guest-physical offset. A 2-bit selection field chooses the view. Whether some of its codes are legal depends on feature-present inputs.

The guest-physical offset can be forced to zero by a dedicated input. When the processing element is in a state where the selection field does not apply, a separate ignore input replaces the field with a default selection. The chosen value is registered, so the stamp appears one clock after its inputs.

A selection that resolves to a reserved code does two things. It raises a flag for that cycle, and it falls back to the raw counter. Counter generation is outside this block.

Top module: `trace_stamp_select`

## Requirements
- R1: Selection code 2'b01 yields stampOut = physCount - virtOffset, computed modulo 2^CW, so a counter below the offset wraps.
- R2: Selection code 2'b10 with hasEcv=1 and zeroPhysOff=0 yields stampOut = physCount - physOffset, computed modulo 2^CW.
- R3: Selection code 2'b10 with hasEcv=1 and zeroPhysOff=1 yields stampOut = physCount. In this case the physical offset has no effect.
- R4: Selection code 2'b11 yields stampOut = physCount, and reservedHit stays 0.
- R5: Selection code 2'b00 behaves exactly as 2'b01 when hasNvRev=1. When hasNvRev=0 it is a reserved code.
- R6: A reserved code (2'b10 with hasEcv=0, or 2'b00 with hasNvRev=0) sets reservedHit=1 and yields stampOut = physCount.
- R7: When fieldIgnored=1, defaultSel is decoded in place of tsField under the same rules, and tsField has no effect on either output.
- R8: Both outputs are registered. They reflect the inputs of the previous rising clock edge and do not change between edges. During reset both outputs are 0.
- R9: For every non-reserved code, reservedHit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| physCount | input | CW | Free-running physical counter |
| virtOffset | input | CW | Virtual counter offset |
| physOffset | input | CW | Guest-physical counter offset |
| tsField | input | 2 | Timestamp source selection field |
| hasEcv | input | 1 | Enhanced counter virtualization present; makes code 2'b10 legal |
| hasNvRev | input | 1 | Later nested-virtualization revision present; makes code 2'b00 act as 2'b01 |
| zeroPhysOff | input | 1 | Forces the guest-physical offset to zero |
| fieldIgnored | input | 1 | Selection field does not apply; use defaultSel |
| defaultSel | input | 2 | Selection used while fieldIgnored is 1 |
| stampOut | output | CW | Registered trace timestamp |
| reservedHit | output | 1 | Registered flag: the effective code was reserved |

## Verification
The hardest case to reach is a reserved code arriving through the default path. This happens when fieldIgnored is set, the default selection is itself reserved, and tsField holds a legal code that must have no influence. The stimulus reaches this case with a full sweep over every combination of the field, the default, the two feature flags, the zero-offset input and the ignore input. Each combination is run under several counter and offset patterns, some with the counter below both offsets so that the subtraction wraps. Before each clock edge the bench also confirms that the outputs still hold the previous result.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  typedef enum logic [1:0] {
    SEL_NV_ALIAS = 2'b00,
    SEL_VIRT     = 2'b01,
    SEL_GUEST    = 2'b10,
    SEL_RAW      = 2'b11
  } selCode_e;

  typedef struct packed {
    logic useVirt;
    logic useGuest;
    logic dropOffset;
    logic reserved;
  } stampStrobe_t;
endpackage

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
  import tstamp_pkg::*;
(
  input  logic [1:0]   tsField,
  input  logic         hasEcv,
  input  logic         hasNvRev,
  input  logic         zeroPhysOff,
  input  logic         fieldIgnored,
  input  logic [1:0]   defaultSel,
  output stampStrobe_t strobe
);
  selCode_e effSel;

  always_comb begin
    effSel = selCode_e'(fieldIgnored ? defaultSel : tsField);
    strobe = '0;
    unique case (effSel)
      SEL_NV_ALIAS: begin
        if (hasNvRev) strobe.useVirt = 1'b1;
        else          strobe.reserved = 1'b1;
      end
      SEL_VIRT: strobe.useVirt = 1'b1;
      SEL_GUEST: begin
        if (hasEcv) begin
          strobe.useGuest   = 1'b1;
          strobe.dropOffset = zeroPhysOff;
        end else begin
          strobe.reserved = 1'b1;
        end
      end
      SEL_RAW: strobe = '0;
      default: strobe.reserved = 1'b1;
    endcase
  end
endmodule

// File: rtl/tstamp_datapath.sv
module tstamp_datapath
  import tstamp_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] physCount,
  input  logic [CW-1:0] virtOffset,
  input  logic [CW-1:0] physOffset,
  input  stampStrobe_t  strobe,
  output logic [CW-1:0] stampOut,
  output logic          reservedHit
);
  logic [CW-1:0] offsetSel;
  logic [CW-1:0] stampNext;

  always_comb begin
    if (strobe.useVirt)
      offsetSel = virtOffset;
    else if (strobe.useGuest && !strobe.dropOffset)
      offsetSel = physOffset;
    else
      offsetSel = '0;
    stampNext = physCount - offsetSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stampOut    <= '0;
      reservedHit <= 1'b0;
    end else begin
      stampOut    <= stampNext;
      reservedHit <= strobe.reserved;
    end
  end
endmodule

// File: rtl/trace_stamp_select.sv
module trace_stamp_select
  import tstamp_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] physCount,
  input  logic [CW-1:0] virtOffset,
  input  logic [CW-1:0] physOffset,
  input  logic [1:0]    tsField,
  input  logic          hasEcv,
  input  logic          hasNvRev,
  input  logic          zeroPhysOff,
  input  logic          fieldIgnored,
  input  logic [1:0]    defaultSel,
  output logic [CW-1:0] stampOut,
  output logic          reservedHit
);
  stampStrobe_t strobe;

  tstamp_ctrl uCtrl (
    .tsField      (tsField),
    .hasEcv       (hasEcv),
    .hasNvRev     (hasNvRev),
    .zeroPhysOff  (zeroPhysOff),
    .fieldIgnored (fieldIgnored),
    .defaultSel   (defaultSel),
    .strobe       (strobe)
  );

  tstamp_datapath #(.CW(CW)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .physCount   (physCount),
    .virtOffset  (virtOffset),
    .physOffset  (physOffset),
    .strobe      (strobe),
    .stampOut    (stampOut),
    .reservedHit (reservedHit)
  );
endmodule

// File: rtl/trace_stamp_select_chk.sv
module trace_stamp_select_chk #(
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rstN,
  input logic [CW-1:0] physCount,
  input logic [CW-1:0] virtOffset,
  input logic [CW-1:0] physOffset,
  input logic [1:0]    tsField,
  input logic          hasEcv,
  input logic          hasNvRev,
  input logic          zeroPhysOff,
  input logic          fieldIgnored,
  input logic [1:0]    defaultSel,
  input logic [CW-1:0] stampOut,
  input logic          reservedHit
);
  logic [1:0]    effSel;
  logic [CW-1:0] virtDiff;
  logic [CW-1:0] guestDiff;

  assign effSel    = fieldIgnored ? defaultSel : tsField;
  assign virtDiff  = physCount - virtOffset;
  assign guestDiff = physCount - physOffset;

  // R1
  a_r1_virt_stamp: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(effSel) == 2'b01) |-> (stampOut == $past(virtDiff) && !reservedHit));

  // R2
  a_r2_guest_stamp: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(effSel) == 2'b10 && $past(hasEcv) && !$past(zeroPhysOff))
      |-> (stampOut == $past(guestDiff)));

  // R3
  a_r3_guest_zero: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(effSel) == 2'b10 && $past(hasEcv) && $past(zeroPhysOff))
      |-> (stampOut == $past(physCount)));

  // R4
  a_r4_raw_stamp: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(effSel) == 2'b11) |-> (stampOut == $past(physCount) && !reservedHit));

  // R5
  a_r5_alias_virt: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(effSel) == 2'b00 && $past(hasNvRev))
      |-> (stampOut == $past(virtDiff) && !reservedHit));

  // R6
  a_r6_reserved_raw: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && reservedHit) |-> (stampOut == $past(physCount)));

  // R6
  a_r6_no_ecv_flag: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(effSel) == 2'b10 && !$past(hasEcv)) |-> reservedHit);

  // R8
  a_r8_reset_clear: assert property (@(posedge clk)
    !rstN |-> (stampOut == '0 && !reservedHit));
endmodule

bind trace_stamp_select trace_stamp_select_chk #(.CW(CW)) uChk (.*);

// File: tb/tb_trace_stamp_select.sv
module tb_trace_stamp_select;
  localparam int CW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] physCount = '0;
  logic [CW-1:0] virtOffset = '0;
  logic [CW-1:0] physOffset = '0;
  logic [1:0]    tsField = '0;
  logic          hasEcv = 1'b0;
  logic          hasNvRev = 1'b0;
  logic          zeroPhysOff = 1'b0;
  logic          fieldIgnored = 1'b0;
  logic [1:0]    defaultSel = '0;
  logic [CW-1:0] stampOut;
  logic          reservedHit;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trace_stamp_select #(.CW(CW)) dut (.*);

  task automatic check64(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s stamp actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s flag actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    logic [CW-1:0] prevStamp;
    logic          prevFlag;
    logic [CW-1:0] cnt [4];
    logic [CW-1:0] vof [4];
    logic [CW-1:0] pof [4];
    cnt[0] = 64'h0000_1234_5678_9ABC; vof[0] = 64'h0000_0000_0000_1000; pof[0] = 64'h0000_0000_0100_0000;
    cnt[1] = 64'h0000_0000_0000_0005; vof[1] = 64'h0000_0000_0000_0010; pof[1] = 64'h0000_0000_0000_0020;
    cnt[2] = 64'hFFFF_FFFF_FFFF_FFFF; vof[2] = 64'hFFFF_FFFF_FFFF_FFFF; pof[2] = 64'h0000_0000_0000_0001;
    cnt[3] = 64'h0000_0000_0000_0000; vof[3] = 64'h8000_0000_0000_0000; pof[3] = 64'hDEAD_BEEF_0000_0001;

    physCount = cnt[0];
    #23;
    check64("R8 reset", stampOut, '0);
    check1("R8 reset", reservedHit, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    prevStamp = stampOut;
    prevFlag  = reservedHit;

    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 128; c++) begin
        logic [1:0]    eff;
        logic [CW-1:0] expStamp;
        logic          expFlag;
        string         tag;
        tsField      = c[1:0];
        defaultSel   = c[3:2];
        hasEcv       = c[4];
        hasNvRev     = c[5];
        zeroPhysOff  = c[6];
        fieldIgnored = p[0];
        physCount    = cnt[p];
        virtOffset   = vof[p];
        physOffset   = pof[p];
        // second half of patterns flips ignore per combination
        if (p >= 2) fieldIgnored = c[0] ^ c[5];
        eff = fieldIgnored ? defaultSel : tsField;
        expFlag = 1'b0;
        if (eff == 2'b01) begin
          expStamp = cnt[p] - vof[p]; tag = "R1";
        end else if (eff == 2'b00 && hasNvRev) begin
          expStamp = cnt[p] - vof[p]; tag = "R5";
        end else if (eff == 2'b00) begin
          expStamp = cnt[p]; expFlag = 1'b1; tag = "R5/R6";
        end else if (eff == 2'b10 && !hasEcv) begin
          expStamp = cnt[p]; expFlag = 1'b1; tag = "R6";
        end else if (eff == 2'b10 && zeroPhysOff) begin
          expStamp = cnt[p]; tag = "R3";
        end else if (eff == 2'b10) begin
          expStamp = cnt[p] - pof[p]; tag = "R2";
        end else begin
          expStamp = cnt[p]; tag = "R4";
        end
        if (fieldIgnored) tag = {tag, " R7"};
        if (!expFlag) tag = {tag, " R9"};
        #1;
        check64("R8 hold", stampOut, prevStamp);
        check1("R8 hold", reservedHit, prevFlag);
        @(negedge clk);
        check64(tag, stampOut, expStamp);
        check1(tag, reservedHit, expFlag);
        prevStamp = expStamp;
        prevFlag  = expFlag;
      end
    end

    // R7: with ignore set, a changing tsField must not move the outputs
    fieldIgnored = 1'b1; defaultSel = 2'b11; hasEcv = 1'b0; hasNvRev = 1'b0;
    physCount = cnt[0]; virtOffset = vof[0]; physOffset = pof[0];
    for (int f = 0; f < 4; f++) begin
      tsField = f[1:0];
      @(negedge clk);
      check64("R7 field ignored", stampOut, cnt[0]);
      check1("R7 field ignored", reservedHit, 1'b0);
    end

    // R8: reset mid-run clears outputs
    rstN = 1'b0;
    #1;
    check64("R8 async reset", stampOut, '0);
    check1("R8 async reset", reservedHit, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule